// File: doc/BRIEF.md
# Interrupt Take and Wake Gate

This block sits between a set of interrupt request lines and a processor core. It decides two things. First, it picks the pending line that the core may take now. Second, it decides when a core in wait-for-interrupt sleep must be woken. Each line has a 4-bit urgency number, where a smaller number is more urgent. Two controls mask the lines: a global-disable flag and a base-priority threshold.

The two decisions apply the masks differently. The threshold blocks both taking and waking. The global-disable flag blocks taking only, so a line held back by that flag alone still wakes a sleeping core. Keeping pending state, vectoring and nesting all happen outside the block. The environment acknowledges a take, clears the line, and drives the pending vector.

Configuration goes through a write port with one-cycle register updates. A read port returns the stored register values. The register map is as follows:
- address 0 holds the global-disable flag in bit 0.
- address 1 holds the threshold in bits 7:4.
- address 2+i holds the urgency of line i in bits 7:4.

Top module: `irq_gate`

## Requirements
- R1: Threshold and line-urgency registers keep only bits 7:4 of the written byte and read back with bits 3:0 as zero. The global-disable register keeps only bit 0 and reads back 8'h01 when set.
- R2: When the threshold is zero, no line is blocked by it.
- R3: When the threshold T is nonzero, a line with urgency number greater than or equal to T is neither taken nor allowed to wake the core. A line with a number below T remains eligible.
- R4: While the global-disable flag is set, take_o stays low whatever is pending.
- R5: Among eligible pending lines, take_o selects the one with the smallest urgency number. On a tie, it selects the lowest line index.
- R6: Once take_o is high, take_o and take_idx_o hold their values until a cycle with take_ack_i high. In the cycle after the acknowledge, the selection is made again from the current inputs.
- R7: A one-cycle sleep_req while awake sets asleep_o high from the next cycle on.
- R8: While asleep, a pending eligible line raises wake_o in the same cycle. The take appears once the core is awake again.
- R9: While asleep with the global-disable flag set, a pending line that passes the threshold raises wake_o, but take_o stays low after waking.
- R10: While asleep, a pending line blocked by the threshold leaves wake_o low, and the core stays asleep.
- R11: While asleep, dbg_req raises wake_o.
- R12: wake_o lasts one cycle, and asleep_o is low in the next cycle. take_o stays low while asleep.
- R13: After reset, the core is awake, take_o and wake_o are low, and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| pend_i | input | NLINES | Pending flag per line |
| take_ack_i | input | 1 | Core has accepted the offered line |
| take_o | output | 1 | A line is offered to the core |
| take_idx_o | output | IDX_W | Index of the offered line |
| sleep_req | input | 1 | One-cycle request to enter sleep |
| dbg_req | input | 1 | Debug-entry request |
| wake_o | output | 1 | One-cycle wake pulse |
| asleep_o | output | 1 | Core is in the sleep state |

## Verification
The assertions assume that the environment behaves like the pending-state storage. A line that is offered stays pending until it is acknowledged. The environment also issues sleep_req only while the core is awake and no take is outstanding. The bench meets these assumptions in three ways. It clears a pending bit only in the cycle of its acknowledge, or after the take has dropped. It changes the pending vector only by adding lines while a take is held. It asks for sleep only with nothing pending.

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NLINES = 8,
  parameter int PRIO_W = 4,
  localparam int IDX_W  = (NLINES > 1) ? $clog2(NLINES) : 1,
  localparam int ADDR_W = $clog2(NLINES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [NLINES-1:0] pend_i,
  input  logic              take_ack_i,
  output logic              take_o,
  output logic [IDX_W-1:0]  take_idx_o,
  input  logic              sleep_req,
  input  logic              dbg_req,
  output logic              wake_o,
  output logic              asleep_o
);
  localparam int LOW_W = 8 - PRIO_W;

  logic              gdis_q;
  logic [PRIO_W-1:0] base_q;
  logic [PRIO_W-1:0] prio_q [NLINES];
  logic              asleep_q, held_q;
  logic [IDX_W-1:0]  idx_q;

  logic [NLINES-1:0] below, elig;
  logic              win_v, live, wake_src;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gdis_q <= 1'b0;
      base_q <= '0;
      for (int i = 0; i < NLINES; i++) prio_q[i] <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(0)) gdis_q <= wr_data[0];
      if (wr_addr == ADDR_W'(1)) base_q <= wr_data[7:LOW_W];
      for (int i = 0; i < NLINES; i++)
        if (wr_addr == ADDR_W'(i + 2)) prio_q[i] <= wr_data[7:LOW_W];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(0)) rd_data = {7'b0, gdis_q};
    if (rd_addr == ADDR_W'(1)) rd_data = {base_q, {LOW_W{1'b0}}};
    for (int i = 0; i < NLINES; i++)
      if (rd_addr == ADDR_W'(i + 2)) rd_data = {prio_q[i], {LOW_W{1'b0}}};
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_mask
    assign below[g] = (base_q == '0) || (prio_q[g] < base_q);
  end

  assign elig     = pend_i & below & {NLINES{~gdis_q}};
  assign wake_src = (|(pend_i & below)) | dbg_req;

  always_comb begin
    win_v   = 1'b0;
    win_idx = '0;
    win_p   = '1;
    for (int i = 0; i < NLINES; i++) begin
      if (elig[i] && (!win_v || prio_q[i] < win_p)) begin
        win_v   = 1'b1;
        win_idx = IDX_W'(i);
        win_p   = prio_q[i];
      end
    end
  end

  assign live       = win_v & ~asleep_q;
  assign take_o     = held_q | live;
  assign take_idx_o = held_q ? idx_q : win_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      idx_q  <= '0;
    end else if (take_o && !take_ack_i) begin
      held_q <= 1'b1;
      idx_q  <= take_idx_o;
    end else begin
      held_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      asleep_q <= 1'b0;
    else if (asleep_q && wake_src)   asleep_q <= 1'b0;
    else if (!asleep_q && sleep_req) asleep_q <= 1'b1;
  end

  assign wake_o   = asleep_q & wake_src;
  assign asleep_o = asleep_q;
endmodule

module irq_gate_chk #(
  parameter int NLINES = 8,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] pend_i,
  input logic              take_ack_i,
  input logic              take_o,
  input logic [IDX_W-1:0]  take_idx_o,
  input logic              sleep_req,
  input logic              dbg_req,
  input logic              wake_o,
  input logic              asleep_o,
  input logic              gdis_q
);
  // R6
  take_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && !take_ack_i |=> take_o && $stable(take_idx_o));

  // R6
  take_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> pend_i[take_idx_o]);

  // R4
  gdis_no_new_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && !$past(take_o) |-> !gdis_q);

  // R7
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !asleep_o && sleep_req |=> asleep_o);

  // R12
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !asleep_o && !wake_o);

  // R10
  quiet_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_o && pend_i == '0 && !dbg_req |-> !wake_o);
endmodule

bind irq_gate irq_gate_chk #(.NLINES(NLINES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .take_ack_i(take_ack_i),
  .take_o(take_o), .take_idx_o(take_idx_o), .sleep_req(sleep_req),
  .dbg_req(dbg_req), .wake_o(wake_o), .asleep_o(asleep_o), .gdis_q(gdis_q)
);

// File: tb/irq_gate_bench.sv
`timescale 1ns/1ps
module irq_gate_bench;
  localparam int N = 8;
  localparam int IW = 3;
  localparam int AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [N-1:0] pend_i = '0;
  logic take_ack_i = 1'b0, sleep_req = 1'b0, dbg_req = 1'b0;
  logic take_o, wake_o, asleep_o;
  logic [IW-1:0] take_idx_o;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  irq_gate #(.NLINES(N)) u_irq_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pend_i(pend_i), .take_ack_i(take_ack_i),
    .take_o(take_o), .take_idx_o(take_idx_o), .sleep_req(sleep_req),
    .dbg_req(dbg_req), .wake_o(wake_o), .asleep_o(asleep_o)
  );

  // urgency per line, line 0 first
  localparam logic [3:0] PR [N] = '{4'd3, 4'd5, 4'd1, 4'd5, 4'd7, 4'd1, 4'd2, 4'd9};
  // {pend[16:9], gdis[8], base[7:4], exp_take[3], exp_idx[2:0]}
  localparam logic [16:0] VEC [10] = '{
    {8'h01, 1'b0, 4'h0, 1'b1, 3'd0},
    {8'hFF, 1'b0, 4'h0, 1'b1, 3'd2},
    {8'h22, 1'b0, 4'h0, 1'b1, 3'd5},
    {8'h0A, 1'b0, 4'h0, 1'b1, 3'd1},
    {8'hFF, 1'b1, 4'h0, 1'b0, 3'd0},
    {8'h01, 1'b0, 4'h3, 1'b0, 3'd0},
    {8'h41, 1'b0, 4'h3, 1'b1, 3'd6},
    {8'h80, 1'b0, 4'h9, 1'b0, 3'd0},
    {8'h90, 1'b0, 4'h9, 1'b1, 3'd4},
    {8'h18, 1'b0, 4'hF, 1'b1, 3'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ack_take();
    take_ack_i = 1'b1;
    @(negedge clk);
    take_ack_i = 1'b0;
  endtask

  task automatic go_sleep();
    @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk("R7 asleep after request", asleep_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [16:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R13 take after reset", take_o, 0);
    chk("R13 wake after reset", wake_o, 0);
    chk("R13 awake after reset", asleep_o, 0);
    for (int a = 0; a < 3; a++) begin
      rd_addr = AW'(a); #1;
      chk("R13 register zero", rd_data, 0);
    end

    for (int i = 0; i < N; i++) wr(AW'(i + 2), {PR[i], 4'hA});
    rd_addr = AW'(2); #1;
    chk("R1 urgency low bits read zero", rd_data, 8'h30);
    wr(1, 8'h35); rd_addr = AW'(1); #1;
    chk("R1 threshold low bits read zero", rd_data, 8'h30);
    wr(0, 8'hFE); rd_addr = AW'(0); #1;
    chk("R1 disable keeps only bit 0 clear", rd_data, 8'h00);
    wr(0, 8'hFF); #1;
    chk("R1 disable reads 01", rd_data, 8'h01);

    for (int k = 0; k < 10; k++) begin
      v = VEC[k];
      wr(0, {7'b0, v[8]});
      wr(1, {v[7:4], 4'h3});
      pend_i = v[16:9];
      #1;
      chk($sformatf("R2 R3 R4 R5 vector %0d take", k), take_o, v[3]);
      if (v[3]) chk($sformatf("R5 vector %0d index", k), take_idx_o, v[2:0]);
      if (take_o) ack_take();
      pend_i = '0;
    end

    wr(0, 8'h00); wr(1, 8'h00);
    @(negedge clk);
    pend_i = 8'h01; #1;
    chk("R6 first offer", take_idx_o, 0);
    @(negedge clk);
    pend_i = 8'h05; #1;
    chk("R6 offer held", take_o, 1);
    chk("R6 index held", take_idx_o, 0);
    ack_take();
    pend_i = 8'h04; #1;
    chk("R6 reselect after ack", take_idx_o, 2);
    ack_take();
    pend_i = '0; #1;
    chk("R6 released", take_o, 0);

    wr(1, 8'h30);
    go_sleep();
    pend_i = 8'h01; #1;
    chk("R10 masked line no wake", wake_o, 0);
    @(negedge clk);
    chk("R10 still asleep", asleep_o, 1);
    chk("R12 no take asleep", take_o, 0);
    pend_i = '0;

    wr(0, 8'h01);
    pend_i = 8'h04; #1;
    chk("R9 disabled line wakes", wake_o, 1);
    chk("R12 no take while asleep", take_o, 0);
    @(negedge clk);
    chk("R12 awake after wake", asleep_o, 0);
    chk("R12 wake one cycle", wake_o, 0);
    chk("R9 no take when disabled", take_o, 0);
    pend_i = '0;

    wr(0, 8'h00);
    go_sleep();
    pend_i = 8'h40; #1;
    chk("R8 eligible line wakes", wake_o, 1);
    chk("R8 no take before wake", take_o, 0);
    @(negedge clk);
    chk("R8 take after wake", take_o, 1);
    chk("R8 take index", take_idx_o, 6);
    ack_take();
    pend_i = '0;

    go_sleep();
    dbg_req = 1'b1; #1;
    chk("R11 debug wakes", wake_o, 1);
    @(negedge clk);
    dbg_req = 1'b0;
    chk("R11 awake after debug", asleep_o, 0);

    wr(1, 8'h00);
    go_sleep();
    pend_i = 8'h80; #1;
    chk("R2 zero threshold lets urgency 9 wake", wake_o, 1);
    @(negedge clk);
    chk("R2 take after wake", take_idx_o, 7);
    ack_take();
    pend_i = '0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule